// File: doc/BRIEF.md
# PTP System Time Keeper

This block holds the running time of a precision time protocol clock as a count of whole seconds plus a binary fraction of a second. The fraction has 31 bits, so it rolls over at 2^31. On every clock the time moves forward by a programmable fraction step. Software drives the block through a small write-only register port. Over this port it stages a seconds value, a signed fraction value and the step size. It then raises one of two commands.

The initialize command overwrites the running time with the staged value. The update command shifts the running time forward or back by the staged value. The direction comes from a sign flag held next to the staged fraction. Carries and borrows cross from the fraction into the seconds, and the seconds wrap modulo 2^32. The step of the current cycle is merged into the update arithmetic, so no tick is lost.

Each command shows as busy for one cycle and then clears by itself. A second command that arrives while one is busy is dropped. An initialize request made with the sign flag set is refused, and a sticky error output records the refusal.

Top module: `ptp_time_keeper`

## Requirements
- R1: After reset the time is zero, both staged values and the sign are zero, no command is busy, the error output is low, and the step equals the parameter INC_RESET.
- R2: When no command takes effect, each clock adds the step to the fraction. A fraction that reaches 2^31 drops 2^31 and adds one second, and the seconds wrap from 2^32-1 to 0.
- R3: A write with wrAddr 0 stages the seconds from wrData[31:0]. Address 1 stages the sign from wrData[31] and the fraction from wrData[30:0]. Address 2 sets the step from wrData[30:0]. Address 3 is the command word, with bit 0 for initialize and bit 1 for update.
- R4: A command written at one clock edge shows its busy output high for exactly the next cycle. The busy output clears at the following edge, which is the same edge at which the command takes effect.
- R5: An initialize with sign 0 sets the time to exactly the staged seconds and fraction. The step is not added in that cycle.
- R6: An update with sign 0 sets the time to the old time plus the step plus the staged value. The fraction carry can move the seconds up by one or by two.
- R7: An update with sign 1 sets the time to the old time plus the step minus the staged value. A fraction borrow takes one second, and the seconds wrap modulo 2^32.
- R8: A command write made while either busy output is high is ignored.
- R9: A command word with both bits set starts only the initialize.
- R10: An initialize raised while the staged sign is 1 leaves the time advancing by the step only, and sets initRefused. initRefused then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select (0 seconds, 1 sign+fraction, 2 step, 3 command) |
| wrData | input | 32 | Write data |
| timeSec | output | 32 | Running time, whole seconds |
| timeSub | output | 31 | Running time, fraction in units of 2^-31 s |
| initBusy | output | 1 | Initialize command pending |
| updBusy | output | 1 | Update command pending |
| initRefused | output | 1 | Sticky flag: initialize was asked with the sign set |

## Verification
The bench builds the block with the default widths of 32 seconds bits and 31 fraction bits, so every word it writes uses the register layout of R3 exactly. It overrides INC_RESET to 100, which makes the reset step show up as a known advance right after reset. Because the step is written at run time, the bench can make it large, close to 2^30, to force a double carry on add. It can also set it to 1 and start from a time just below 2^32 seconds, so the seconds wrap and the subtract borrow both happen within a few cycles. A 63-bit reference total, seconds times 2^31 plus fraction, checks random mixes of writes and commands against these directed cases.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

  typedef enum logic [1:0] {
    REG_SEC    = 2'd0,
    REG_SUBSGN = 2'd1,
    REG_STEP   = 2'd2,
    REG_CMD    = 2'd3
  } regSel_t;

  localparam int CMD_INIT_BIT = 0;
  localparam int CMD_UPD_BIT  = 1;
  localparam int ADJ_W        = 3;

  typedef struct packed {
    logic loadInit;
    logic applyUpdate;
    logic subtract;
  } timeStrobe_t;

endpackage

// File: rtl/ptp_time_ctrl.sv
module ptp_time_ctrl
  import ptp_time_pkg::*;
#(
  parameter int SEC_W     = 32,
  parameter int SUB_W     = 31,
  parameter int WORD_W    = 32,
  parameter int INC_RESET = 43
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [SEC_W-1:0]  stgSec,
  output logic [SUB_W-1:0]  stgSub,
  output logic [SUB_W-1:0]  stepVal,
  output timeStrobe_t       strobe,
  output logic              initBusy,
  output logic              updBusy,
  output logic              initRefused
);

  logic    stgSign;
  logic    initPend;
  logic    updPend;
  logic    errFlag;
  regSel_t regSel;
  logic    cmdWrite;
  logic    cmdFree;
  logic    reqInit;
  logic    reqUpd;

  assign regSel   = regSel_t'(wrAddr);
  assign cmdWrite = wrEn && (regSel == REG_CMD);
  assign cmdFree  = !(initPend || updPend);
  assign reqInit  = cmdWrite && cmdFree && wrData[CMD_INIT_BIT];
  assign reqUpd   = cmdWrite && cmdFree && wrData[CMD_UPD_BIT] && !wrData[CMD_INIT_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgSec  <= '0;
      stgSub  <= '0;
      stgSign <= 1'b0;
      stepVal <= SUB_W'(INC_RESET);
    end else if (wrEn) begin
      unique case (regSel)
        REG_SEC:    stgSec <= wrData[SEC_W-1:0];
        REG_SUBSGN: begin
          stgSub  <= wrData[SUB_W-1:0];
          stgSign <= wrData[SUB_W];
        end
        REG_STEP:   stepVal <= wrData[SUB_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initPend <= 1'b0;
      updPend  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      initPend <= reqInit;
      updPend  <= reqUpd;
      if (initPend && stgSign) errFlag <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadInit    = initPend && !stgSign;
    strobe.applyUpdate = updPend;
    strobe.subtract    = stgSign;
  end

  assign initBusy    = initPend;
  assign updBusy     = updPend;
  assign initRefused = errFlag;

  assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (initBusy || updBusy) |=> !(initBusy || updBusy));

  assert_ignore_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3 && (initBusy || updBusy)) |=> !(initBusy || updBusy));

  assert_single_command_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({initBusy, updBusy}));

  assert_refuse_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    initRefused |=> initRefused);

  assert_refuse_sets_R10: assert property (@(posedge clk) disable iff (!rstN)
    (initBusy && stgSign) |=> initRefused);

endmodule

// File: rtl/ptp_time_datapath.sv
module ptp_time_datapath
  import ptp_time_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  timeStrobe_t      strobe,
  input  logic [SEC_W-1:0] stgSec,
  input  logic [SUB_W-1:0] stgSub,
  input  logic [SUB_W-1:0] stepVal,
  output logic [SEC_W-1:0] timeSec,
  output logic [SUB_W-1:0] timeSub
);

  localparam int EXT_W = SUB_W + ADJ_W;

  logic signed [EXT_W-1:0] curExt;
  logic signed [EXT_W-1:0] stepExt;
  logic signed [EXT_W-1:0] stgExt;
  logic signed [EXT_W-1:0] stgTerm;
  logic signed [EXT_W-1:0] subSum;
  logic        [SEC_W-1:0] secAdj;
  logic        [SEC_W-1:0] secDelta;
  logic        [SEC_W-1:0] nextSec;
  logic        [SUB_W-1:0] nextSub;

  always_comb begin
    curExt  = signed'({{ADJ_W{1'b0}}, timeSub});
    stepExt = signed'({{ADJ_W{1'b0}}, stepVal});
    stgExt  = signed'({{ADJ_W{1'b0}}, stgSub});
    if (!strobe.applyUpdate)  stgTerm = '0;
    else if (strobe.subtract) stgTerm = -stgExt;
    else                      stgTerm = stgExt;
    subSum = curExt + stepExt + stgTerm;
    nextSub = subSum[SUB_W-1:0];
    secAdj  = {{(SEC_W-ADJ_W){subSum[EXT_W-1]}}, subSum[EXT_W-1:SUB_W]};
    if (!strobe.applyUpdate)  secDelta = '0;
    else if (strobe.subtract) secDelta = -stgSec;
    else                      secDelta = stgSec;
    nextSec = timeSec + secDelta + secAdj;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeSec <= '0;
      timeSub <= '0;
    end else if (strobe.loadInit) begin
      timeSec <= stgSec;
      timeSub <= stgSub;
    end else begin
      timeSec <= nextSec;
      timeSub <= nextSub;
    end
  end

  assert_init_loads_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInit |=> (timeSec == $past(stgSec)) && (timeSub == $past(stgSub)));

  assert_free_run_seconds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadInit || strobe.applyUpdate) |=>
      (timeSec == $past(timeSec)) || (timeSec == $past(timeSec) + 1'b1));

  assert_free_run_fraction_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadInit || strobe.applyUpdate) |=>
      (timeSub == SUB_W'($past(timeSub) + $past(stepVal))));

  assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadInit && strobe.applyUpdate));

endmodule

// File: rtl/ptp_time_keeper.sv
module ptp_time_keeper
  import ptp_time_pkg::*;
#(
  parameter int SEC_W     = 32,
  parameter int SUB_W     = 31,
  parameter int INC_RESET = 43,
  localparam int WORD_W   = (SEC_W > SUB_W + 1) ? SEC_W : SUB_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [SEC_W-1:0]  timeSec,
  output logic [SUB_W-1:0]  timeSub,
  output logic              initBusy,
  output logic              updBusy,
  output logic              initRefused
);

  timeStrobe_t      strobe;
  logic [SEC_W-1:0] stgSec;
  logic [SUB_W-1:0] stgSub;
  logic [SUB_W-1:0] stepVal;

  ptp_time_ctrl #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .WORD_W(WORD_W), .INC_RESET(INC_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stgSec(stgSec), .stgSub(stgSub), .stepVal(stepVal), .strobe(strobe),
    .initBusy(initBusy), .updBusy(updBusy), .initRefused(initRefused)
  );

  ptp_time_datapath #(
    .SEC_W(SEC_W), .SUB_W(SUB_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stgSec(stgSec), .stgSub(stgSub),
    .stepVal(stepVal), .timeSec(timeSec), .timeSub(timeSub)
  );

endmodule

// File: tb/ptp_time_keeper_test.sv
`timescale 1ns/1ps
module ptp_time_keeper_test;

  localparam int RST_STEP = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] timeSec;
  logic [30:0] timeSub;
  logic        initBusy, updBusy, initRefused;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  ptp_time_keeper #(.SEC_W(32), .SUB_W(31), .INC_RESET(RST_STEP)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timeSec(timeSec), .timeSub(timeSub), .initBusy(initBusy),
    .updBusy(updBusy), .initRefused(initRefused)
  );

  always #4 clk = ~clk;

  // Reference: total = seconds*2^31 + fraction, arithmetic modulo 2^63
  logic [62:0] mTotal;
  logic [31:0] mSec;
  logic [30:0] mSub;
  logic        mSign;
  logic [30:0] mStep;
  logic        mInitP, mUpdP, mErr;

  function automatic logic [62:0] stagedTotal(input logic [31:0] s, input logic [30:0] f);
    return {s, f};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTotal <= '0; mSec <= '0; mSub <= '0; mSign <= 1'b0;
      mStep <= 31'(RST_STEP); mInitP <= 1'b0; mUpdP <= 1'b0; mErr <= 1'b0;
    end else begin
      if (mInitP && !mSign) mTotal <= stagedTotal(mSec, mSub);
      else if (mUpdP && !mSign) mTotal <= mTotal + 63'(mStep) + stagedTotal(mSec, mSub);
      else if (mUpdP && mSign)  mTotal <= mTotal + 63'(mStep) - stagedTotal(mSec, mSub);
      else mTotal <= mTotal + 63'(mStep);
      if (mInitP && mSign) mErr <= 1'b1;
      mInitP <= 1'b0;
      mUpdP  <= 1'b0;
      if (wrEn) begin
        case (wrAddr)
          2'd0: mSec <= wrData;
          2'd1: begin mSub <= wrData[30:0]; mSign <= wrData[31]; end
          2'd2: mStep <= wrData[30:0];
          default: if (!(mInitP || mUpdP)) begin
            mInitP <= wrData[0];
            mUpdP  <= wrData[1] && !wrData[0];
          end
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, 64'({timeSec, timeSub}), 64'(mTotal));
    check(req, 64'({initBusy, updBusy, initRefused}), 64'({mInitP, mUpdP, mErr}));
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    // R1 reset state
    check("R1 time", 64'({timeSec, timeSub}), 64'd0);
    check("R1 flags", 64'({initBusy, updBusy, initRefused}), 64'd0);
    rstN = 1'b1;
    idle(1);
    check("R1 reset step", 64'({timeSec, timeSub}), 64'(RST_STEP));
    // R1 staged zero: update adds only the step
    writeReg(2'd3, 32'h2);
    check("R4 update busy", 64'({initBusy, updBusy}), 64'b01);
    idle(1);
    check("R1 zero stage", 64'({timeSec, timeSub}), 64'(3 * RST_STEP));
    checkAll("R4 busy cleared");

    // R3 R5 initialize
    writeReg(2'd0, 32'd5);
    writeReg(2'd1, 32'd1000);
    writeReg(2'd3, 32'h1);
    check("R4 init busy", 64'({initBusy, updBusy}), 64'b10);
    idle(1);
    check("R5 init exact", 64'({timeSec, timeSub}), {1'b0, 32'd5, 31'd1000});
    checkAll("R5 init");

    // R6 double carry
    writeReg(2'd2, 32'h4000_0000);
    writeReg(2'd0, 32'd7);
    writeReg(2'd1, 32'h7FFF_FFF0);
    writeReg(2'd3, 32'h1);
    idle(1);
    writeReg(2'd0, 32'd1);
    writeReg(2'd1, 32'h7FFF_FFFF);
    writeReg(2'd3, 32'h2);
    idle(1);
    checkAll("R6 carry add");

    // R7 borrow into seconds with wrap
    writeReg(2'd2, 32'd1);
    writeReg(2'd0, 32'd0);
    writeReg(2'd1, 32'd3);
    writeReg(2'd3, 32'h1);
    idle(1);
    writeReg(2'd1, 32'h8000_0000 | 32'd10);
    writeReg(2'd3, 32'h2);
    idle(1);
    check("R7 borrow wrap", 64'(timeSec), 64'(32'hFFFF_FFFF));
    checkAll("R7 subtract");

    // R2 free-run seconds wrap
    writeReg(2'd0, 32'hFFFF_FFFF);
    writeReg(2'd1, 32'h7FFF_FFFD);
    writeReg(2'd3, 32'h1);
    idle(1);
    check("R2 before wrap", 64'({timeSec, timeSub}), {1'b0, 32'hFFFF_FFFF, 31'h7FFF_FFFD});
    idle(4);
    check("R2 seconds wrap", 64'({timeSec, timeSub}), 64'd1);
    checkAll("R2 free run");

    // R8 command while busy ignored
    writeReg(2'd0, 32'd9);
    writeReg(2'd1, 32'd50);
    writeReg(2'd3, 32'h2);
    writeReg(2'd3, 32'h1);
    check("R8 ignored init", 64'({initBusy, updBusy}), 64'b00);
    checkAll("R8 ignore");

    // R9 both bits
    writeReg(2'd3, 32'h3);
    check("R9 init only", 64'({initBusy, updBusy}), 64'b10);
    idle(1);
    checkAll("R9 both bits");

    // R10 refused initialize
    writeReg(2'd1, 32'h8000_0005);
    writeReg(2'd3, 32'h1);
    idle(1);
    check("R10 refused", 64'(initRefused), 64'd1);
    checkAll("R10 refuse");
    writeReg(2'd1, 32'd5);
    writeReg(2'd3, 32'h1);
    idle(2);
    check("R10 sticky", 64'(initRefused), 64'd1);
    checkAll("R10 after");

    // Random mix: R2 R3 R6 R7
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: writeReg(2'd0, $urandom);
        1: writeReg(2'd1, $urandom);
        2: writeReg(2'd2, $urandom & 32'h3FFF_FFFF);
        3: writeReg(2'd3, $urandom & 32'h3);
        4: writeReg(2'd3, 32'h2);
        default: idle(int'($urandom % 3) + 1);
      endcase
      checkAll("R2 R3 R6 R7 random");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule